// File: doc/BRIEF.md
# Cyclic Convolution Polynomial Multiplier

This block multiplies two polynomials in the ring of integer polynomials taken modulo x^N − 1. Every coefficient is kept modulo q = 2^CW. Each output coefficient k collects every product a[i]·b[j] whose index sum wraps to k, that is (i + j) mod N = k. This product is the costly step of lattice-based encryption and decryption. The default set is N = 397 with 9-bit coefficients.

Software or a sequencer first writes the two operands one coefficient per cycle through a shared index and data bus, with a separate write enable for each operand. It then pulses `start`. A bank of A parallel multiply-accumulate lanes, called atoms, each works on one output coefficient per pass. A lane adds T products per cycle through a balanced adder tree. A pass takes ceil(N/T) cycles, and the run takes ceil(N/A) passes. When the run completes, `done` pulses for one cycle and the whole product can be read by index. Raising A shortens the run and leaves the per-lane logic depth unchanged. Raising T also shortens the run, but it deepens the adder tree.

Top module: `cconv_mul`

## Requirements
- R1: After a run, result coefficient k equals the sum of a[i]·b[(k − i) mod N] over all i in 0..N−1, for every k in 0..N−1.
- R2: All products and sums are taken modulo 2^CW. The stored result is the exact sum truncated to its low CW bits.
- R3: A `start` accepted while idle raises `busy` from the next cycle on. `done` is high for exactly one cycle, ceil(N/A)·ceil(N/T) cycles after the accepting clock edge. In that same cycle `busy` drops, and `done` is never high together with `busy`.
- R4: Operand writes (`a_we` or `b_we`) presented while `busy` is high change neither operand bank.
- R5: A write whose index is N or larger is discarded. A read whose index is N or larger returns 0.
- R6: A `start` presented while `busy` is high is ignored, and the run in progress keeps its timing.
- R7: After reset, `busy` and `done` are low, and both operands and every result coefficient are 0.
- R8: The operands are kept after a run. A second `start` with no new writes reproduces the same result.
- R9: The result does not depend on the choice of A and T.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a multiplication; taken only while idle |
| a_we | input | 1 | Write `wr_data` into operand a at `wr_idx` |
| b_we | input | 1 | Write `wr_data` into operand b at `wr_idx` |
| wr_idx | input | AW | Coefficient index for operand writes |
| wr_data | input | CW | Coefficient value for operand writes |
| rd_idx | input | AW | Result coefficient index to read |
| busy | output | 1 | High while a multiplication is running |
| done | output | 1 | One-cycle pulse when the result is complete |
| rd_data | output | CW | Result coefficient at `rd_idx` (combinational) |

## Verification
Faults in the wrapped index arithmetic or in the accumulator clear appear as result coefficients with the wrong value. The two probes x^0 and x^(N−1) place those errors at known positions: the first must return b unchanged, and the second must return b rotated by one place. A sweep of a = x^m over every m checks each wrap offset. A schedule fault, such as a missing pass or a wrong step count, shows at the ports as a `done` pulse in the wrong cycle, and the bench catches that within a single run. Errors on the last pass, which is only partly filled, corrupt only the top coefficients, so the bench reads back every index on every run.

// File: rtl/cconv_pkg.sv
package cconv_pkg;

    // Width of the internal schedule indices; bounds N at 2^IDX_W - 1.
    localparam int IDX_W = 16;

    typedef logic [IDX_W-1:0] idx_t;

    typedef enum logic {
        ST_IDLE,
        ST_RUN
    } run_state_e;

    // Broadcast from the sequencer to every lane each cycle.
    typedef struct packed {
        logic run;    // a compute step happens this cycle
        logic first;  // first step of a pass: accumulator restarts
        logic last;   // last step of a pass: lane commits its coefficient
        idx_t kbase;  // output index handled by lane 0 in this pass
        idx_t ibase;  // first operand-a index summed in this step
    } sched_t;

    function automatic int ceil_div(input int x, input int y);
        return (x + y - 1) / y;
    endfunction

endpackage

// File: rtl/cconv_bank.sv
module cconv_bank #(
    parameter int N  = 397,
    parameter int CW = 9,
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] idx,
    input  logic [CW-1:0] wdata,
    output logic [CW-1:0] mem [N]
);

    localparam logic [AW:0] LIMIT = (AW+1)'(N);

    logic idx_ok;
    assign idx_ok = {1'b0, idx} < LIMIT;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int e = 0; e < N; e++) begin
                mem[e] <= '0;
            end
        end else if (we && idx_ok) begin
            mem[idx] <= wdata;
        end
    end

endmodule

// File: rtl/cconv_ctrl.sv
module cconv_ctrl
    import cconv_pkg::*;
#(
    parameter int N = 397,
    parameter int A = 8,
    parameter int T = 3
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    output sched_t sched,
    output logic   busy,
    output logic   done
);

    localparam int   PASSES = ceil_div(N, A);
    localparam int   STEPS  = ceil_div(N, T);
    localparam idx_t STEP_LAST = idx_t'(STEPS - 1);
    localparam idx_t PASS_LAST = idx_t'(PASSES - 1);
    localparam idx_t K_STRIDE  = idx_t'(A);
    localparam idx_t I_STRIDE  = idx_t'(T);

    run_state_e state;
    idx_t       step_q;
    idx_t       pass_q;
    idx_t       kbase_q;
    idx_t       ibase_q;
    logic       done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            step_q  <= '0;
            pass_q  <= '0;
            kbase_q <= '0;
            ibase_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        state   <= ST_RUN;
                        step_q  <= '0;
                        pass_q  <= '0;
                        kbase_q <= '0;
                        ibase_q <= '0;
                    end
                end
                ST_RUN: begin
                    if (step_q == STEP_LAST) begin
                        step_q  <= '0;
                        ibase_q <= '0;
                        if (pass_q == PASS_LAST) begin
                            state  <= ST_IDLE;
                            done_q <= 1'b1;
                        end else begin
                            pass_q  <= pass_q + idx_t'(1);
                            kbase_q <= kbase_q + K_STRIDE;
                        end
                    end else begin
                        step_q  <= step_q + idx_t'(1);
                        ibase_q <= ibase_q + I_STRIDE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        sched.run   = (state == ST_RUN);
        sched.first = (step_q == '0);
        sched.last  = (step_q == STEP_LAST);
        sched.kbase = kbase_q;
        sched.ibase = ibase_q;
    end

    assign busy = (state == ST_RUN);
    assign done = done_q;

endmodule

// File: rtl/cconv_atom.sv
module cconv_atom
    import cconv_pkg::*;
#(
    parameter int N  = 397,
    parameter int CW = 9,
    parameter int T  = 3,
    parameter int M  = 0,
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  sched_t        sched,
    input  logic [CW-1:0] a_mem [N],
    input  logic [CW-1:0] b_mem [N],
    output logic          wr_en,
    output logic [AW-1:0] wr_k,
    output logic [CW-1:0] wr_val
);

    localparam int   LV    = (T > 1) ? $clog2(T) : 0;
    localparam int   TP    = 1 << LV;
    localparam idx_t IDX_N = idx_t'(N);
    localparam logic [AW-1:0] N_AW = AW'(N);

    idx_t k;
    logic k_ok;
    assign k    = sched.kbase + idx_t'(M);
    assign k_ok = k < IDX_N;

    logic [CW-1:0] prod [T];

    // One product per term; b index wraps as (k - i) mod N in AW bits.
    for (genvar t = 0; t < T; t++) begin : g_term
        idx_t          i;
        logic          i_ok;
        logic [AW-1:0] bi;
        assign i    = sched.ibase + idx_t'(t);
        assign i_ok = i < IDX_N;
        assign bi   = k[AW-1:0] - i[AW-1:0] + ((k < i) ? N_AW : '0);
        assign prod[t] = i_ok ? a_mem[i[AW-1:0]] * b_mem[bi] : '0;
    end

    // Balanced adder tree, padded with zeros up to a power of two.
    for (genvar l = 0; l <= LV; l++) begin : g_lvl
        logic [CW-1:0] v [TP >> l];
        if (l == 0) begin : g_leaf
            for (genvar t = 0; t < TP; t++) begin : g_pad
                if (t < T) begin : g_use
                    assign v[t] = prod[t];
                end else begin : g_zero
                    assign v[t] = '0;
                end
            end
        end else begin : g_sum
            for (genvar j = 0; j < (TP >> l); j++) begin : g_add
                assign v[j] = g_lvl[l-1].v[2*j] + g_lvl[l-1].v[2*j+1];
            end
        end
    end

    logic [CW-1:0] tree_sum;
    logic [CW-1:0] acc;
    logic [CW-1:0] acc_next;

    assign tree_sum = g_lvl[LV].v[0];

    always_comb begin
        acc_next = (sched.first ? '0 : acc) + tree_sum;
    end

    // Hold mux: the accumulator only moves on compute steps.
    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
        end else if (sched.run) begin
            acc <= acc_next;
        end
    end

    assign wr_en  = sched.run & sched.last & k_ok;
    assign wr_k   = k[AW-1:0];
    assign wr_val = acc_next;

endmodule

// File: rtl/cconv_mul.sv
module cconv_mul
    import cconv_pkg::*;
#(
    parameter int N  = 397,
    parameter int CW = 9,
    parameter int A  = 8,
    parameter int T  = 3,
    localparam int AW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          a_we,
    input  logic          b_we,
    input  logic [AW-1:0] wr_idx,
    input  logic [CW-1:0] wr_data,
    input  logic [AW-1:0] rd_idx,
    output logic          busy,
    output logic          done,
    output logic [CW-1:0] rd_data
);

    localparam logic [AW:0] LIMIT = (AW+1)'(N);

    sched_t        sched;
    logic [CW-1:0] a_mem [N];
    logic [CW-1:0] b_mem [N];
    logic [CW-1:0] res   [N];

    logic [A-1:0]  wr_en;
    logic [AW-1:0] wr_k   [A];
    logic [CW-1:0] wr_val [A];

    cconv_ctrl #(.N(N), .A(A), .T(T)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .sched (sched),
        .busy  (busy),
        .done  (done)
    );

    cconv_bank #(.N(N), .CW(CW), .AW(AW)) u_bank_a (
        .clk   (clk),
        .rst   (rst),
        .we    (a_we & ~busy),
        .idx   (wr_idx),
        .wdata (wr_data),
        .mem   (a_mem)
    );

    cconv_bank #(.N(N), .CW(CW), .AW(AW)) u_bank_b (
        .clk   (clk),
        .rst   (rst),
        .we    (b_we & ~busy),
        .idx   (wr_idx),
        .wdata (wr_data),
        .mem   (b_mem)
    );

    for (genvar m = 0; m < A; m++) begin : g_atom
        cconv_atom #(.N(N), .CW(CW), .T(T), .M(m), .AW(AW)) u_atom (
            .clk    (clk),
            .rst    (rst),
            .sched  (sched),
            .a_mem  (a_mem),
            .b_mem  (b_mem),
            .wr_en  (wr_en[m]),
            .wr_k   (wr_k[m]),
            .wr_val (wr_val[m])
        );
    end

    // Lanes in one pass always target distinct indices.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int e = 0; e < N; e++) begin
                res[e] <= '0;
            end
        end else begin
            for (int m = 0; m < A; m++) begin
                if (wr_en[m]) begin
                    res[wr_k[m]] <= wr_val[m];
                end
            end
        end
    end

    assign rd_data = ({1'b0, rd_idx} < LIMIT) ? res[rd_idx] : '0;

endmodule

// File: rtl/cconv_mul_chk.sv
module cconv_mul_chk
    import cconv_pkg::*;
#(
    parameter int N  = 397,
    parameter int CW = 9,
    parameter int A  = 8,
    parameter int T  = 3,
    parameter int AW = 9
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic [AW-1:0] rd_idx,
    input logic [CW-1:0] rd_data
);

    localparam int LAT = ceil_div(N, A) * ceil_div(N, T);
    localparam logic [AW:0] LIMIT = (AW+1)'(N);

    int run_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= 0;
        end else if (start && !busy) begin
            run_cnt <= 0;
        end else if (busy) begin
            run_cnt <= run_cnt + 1;
        end
    end

    a_r3_done_latency: assert property (@(posedge clk) disable iff (rst)
        done |-> (run_cnt == LAT));

    a_r3_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r3_done_not_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    a_r3_busy_ends_with_done: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    a_r6_busy_from_idle_start: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(start) && !$past(busy)));

    a_r5_read_out_of_range: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, rd_idx} >= LIMIT) |-> (rd_data == '0));

    a_r7_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!busy && !done));

endmodule

bind cconv_mul cconv_mul_chk #(
    .N(N), .CW(CW), .A(A), .T(T), .AW(AW)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .rd_idx  (rd_idx),
    .rd_data (rd_data)
);

// File: tb/cconv_mul_tb_top.sv
`timescale 1ns/1ps
module cconv_mul_tb_top;

    localparam int NB   = 7;
    localparam int CWB  = 5;
    localparam int AWB  = 3;
    localparam int MASK = (1 << CWB) - 1;
    localparam int LAT1 = 4 * 3;   // A=2, T=3
    localparam int LAT2 = 3 * 7;   // A=3, T=1

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           start = 1'b0;
    logic           a_we = 1'b0;
    logic           b_we = 1'b0;
    logic [AWB-1:0] wr_idx = '0;
    logic [CWB-1:0] wr_data = '0;
    logic [AWB-1:0] rd_idx = '0;
    logic           busy1, done1, busy2, done2;
    logic [CWB-1:0] rd1, rd2;

    int n_tests = 0;
    int n_fail  = 0;
    int ra [NB];
    int rb [NB];

    always #2.5 clk = ~clk;

    cconv_mul #(.N(NB), .CW(CWB), .A(2), .T(3)) dut_i (
        .clk(clk), .rst(rst), .start(start), .a_we(a_we), .b_we(b_we),
        .wr_idx(wr_idx), .wr_data(wr_data), .rd_idx(rd_idx),
        .busy(busy1), .done(done1), .rd_data(rd1)
    );

    cconv_mul #(.N(NB), .CW(CWB), .A(3), .T(1)) dut_b_i (
        .clk(clk), .rst(rst), .start(start), .a_we(a_we), .b_we(b_we),
        .wr_idx(wr_idx), .wr_data(wr_data), .rd_idx(rd_idx),
        .busy(busy2), .done(done2), .rd_data(rd2)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int expect_k(input int k);
        int s = 0;
        for (int i = 0; i < NB; i++) begin
            s += ra[i] * rb[(k - i + NB) % NB];
        end
        return s & MASK;
    endfunction

    task automatic load_ops();
        for (int i = 0; i < NB; i++) begin
            @(negedge clk);
            a_we = 1'b1; b_we = 1'b0; wr_idx = AWB'(i); wr_data = CWB'(ra[i]);
            @(negedge clk);
            a_we = 1'b0; b_we = 1'b1; wr_data = CWB'(rb[i]);
        end
        @(negedge clk);
        b_we = 1'b0;
    endtask

    // Latency counted in edges after the accepting edge (R3); optional
    // writes and a second start in the middle of the run (R4, R6).
    task automatic run_op(input string tag, input bit disturb);
        int c1 = -1, c2 = -1, p1 = 0, p2 = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check({tag, " R3"}, "busy cfg1 after start", int'(busy1), 1);
        check({tag, " R3"}, "busy cfg2 after start", int'(busy2), 1);
        for (int cyc = 0; cyc < 30; cyc++) begin
            if (done1) begin p1++; if (c1 < 0) c1 = cyc; end
            if (done2) begin p2++; if (c2 < 0) c2 = cyc; end
            if (done1 && busy1) check({tag, " R3"}, "done with busy cfg1", 1, 0);
            if (done2 && busy2) check({tag, " R3"}, "done with busy cfg2", 1, 0);
            if (disturb && cyc == 2) begin
                a_we = 1'b1; b_we = 1'b1; wr_idx = '0;
                wr_data = CWB'(ra[0] + 5); start = 1'b1;
            end else begin
                a_we = 1'b0; b_we = 1'b0; start = 1'b0;
            end
            @(negedge clk);
        end
        check({tag, " R3"}, "done cycle cfg1", c1, LAT1);
        check({tag, " R3"}, "done cycle cfg2", c2, LAT2);
        check({tag, " R3"}, "done pulses cfg1", p1, 1);
        check({tag, " R3"}, "done pulses cfg2", p2, 1);
    endtask

    task automatic read_all(input string tag);
        for (int k = 0; k < NB; k++) begin
            rd_idx = AWB'(k);
            #1;
            check({tag, " R9 cfg1"}, $sformatf("coef %0d", k), int'(rd1), expect_k(k));
            check({tag, " R9 cfg2"}, $sformatf("coef %0d", k), int'(rd2), expect_k(k));
        end
    endtask

    task automatic rand_b();
        for (int i = 0; i < NB; i++) rb[i] = int'($urandom_range(0, MASK));
    endtask

    task automatic rand_a();
        for (int i = 0; i < NB; i++) ra[i] = int'($urandom_range(0, MASK));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R3 watchdog: got 100000 cycles expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        for (int i = 0; i < NB; i++) begin ra[i] = 0; rb[i] = 0; end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R7: reset state
        check("R7", "busy cfg1", int'(busy1), 0);
        check("R7", "busy cfg2", int'(busy2), 0);
        check("R7", "done cfg1", int'(done1), 0);
        check("R7", "done cfg2", int'(done2), 0);
        read_all("R7 reset");

        // R7/R1: operands cleared by reset, zero product
        run_op("R7 zero", 1'b0);
        read_all("R7 R1 zero");

        // R1: a = x^0 returns b
        rand_b();
        for (int i = 0; i < NB; i++) ra[i] = (i == 0) ? 1 : 0;
        load_ops();
        run_op("R1 unit", 1'b0);
        read_all("R1 unit");

        // R1: a = x^(N-1) rotates b down by one
        rand_b();
        for (int i = 0; i < NB; i++) ra[i] = (i == NB - 1) ? 1 : 0;
        load_ops();
        run_op("R1 top", 1'b0);
        read_all("R1 top");

        // R1: every monomial shift, scaled
        for (int m = 0; m < NB; m++) begin
            rand_b();
            for (int i = 0; i < NB; i++) ra[i] = (i == m) ? 3 : 0;
            load_ops();
            run_op("R1 shift", 1'b0);
            read_all("R1 shift");
        end

        // R2: largest coefficients force wrap modulo 2^CW
        for (int i = 0; i < NB; i++) begin ra[i] = MASK; rb[i] = MASK; end
        load_ops();
        run_op("R2 max", 1'b0);
        read_all("R2 max");

        // R1/R2: random operands
        for (int r = 0; r < 20; r++) begin
            rand_a();
            rand_b();
            load_ops();
            run_op("R1 R2 rand", 1'b0);
            read_all("R1 R2 rand");
        end

        // R4/R6: writes and start during a run are ignored
        rand_a();
        rand_b();
        load_ops();
        run_op("R4 R6", 1'b1);
        read_all("R4 R6");

        // R8: rerun without reload gives the same product
        run_op("R8", 1'b0);
        read_all("R8");

        // R5: out-of-range write discarded, out-of-range read is zero
        @(negedge clk);
        a_we = 1'b1; b_we = 1'b1; wr_idx = AWB'(NB); wr_data = CWB'(MASK);
        @(negedge clk);
        a_we = 1'b0; b_we = 1'b0;
        run_op("R5", 1'b0);
        read_all("R5");
        rd_idx = AWB'(NB);
        #1;
        check("R5", "read at N cfg1", int'(rd1), 0);
        check("R5", "read at N cfg2", int'(rd2), 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule